// File: doc/BRIEF.md
# Nested-Priority Interrupt Resolver

This block takes eight level-sensitive interrupt request lines and decides when the processor should be interrupted. Requests are captured into a request latch on every clock. Levels whose service routines have started are held in an in-service register. Priority is fixed: line 0 is the most urgent and line 7 the least. The interrupt output rises only when the most urgent pending request gets past the most urgent level currently in service.

An acknowledge strobe does three things. It records the winning level in the in-service register, removes that level from the request latch, and presents the level's index on a vector output. A non-specific end-of-interrupt strobe retires the most urgent in-service level. In automatic mode, that level retires by itself when the acknowledge pulse ends.

A mode input selects the nesting rule. In the normal rule, an in-service level blocks requests at its own level and every lower level. In the special rule, it blocks only strictly lower levels, so a cascaded source can interrupt again on the same line. The in-service register is readable, so software can confirm it is empty before retiring an upstream level.

Top module: `irqn_resolver`

## Requirements
- R1: After synchronous reset, int_o is 0, isr_o is all zeros and vec_o is 0.
- R2: A request held on req_i produces int_o high on the second rising clock edge, provided it passes the nesting rule against isr_o. With no request pending, int_o is low.
- R3: Bit index 0 of req_i has the highest priority. On acknowledge, vec_o takes the index of the lowest-numbered pending request that passes the nesting rule.
- R4: The rising edge of ack_i sets that winning level's bit in isr_o (bit i means level i) and clears its request latch bit for that cycle.
- R5: With special_i low, a set isr_o bit blocks requests at the same level and at every higher-numbered level.
- R6: With special_i high, a set isr_o bit blocks only higher-numbered levels. A request at the same level, or a lower-numbered level, raises int_o.
- R7: An eoi_i pulse clears only the lowest-numbered set bit of isr_o.
- R8: With aeoi_i high, the acknowledged level's isr_o bit is set while ack_i is high and is cleared on the clock edge where ack_i is first seen low.
- R9: An acknowledge with no eligible request gives vec_o = 7 (the lowest-priority index) and leaves isr_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| special_i | input | 1 | 1 selects the special nesting rule |
| aeoi_i | input | 1 | 1 selects automatic end-of-interrupt |
| req_i | input | 8 | Level-sensitive request lines, bit 0 most urgent |
| ack_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| int_o | output | 1 | Registered interrupt request to the processor |
| vec_o | output | 3 | Index of the level granted by the last acknowledge |
| isr_o | output | 8 | In-service register |

## Verification
The bench builds the block with the default width of eight lines. This puts both ends of the priority order within reach: level 0 as the top winner and level 7 as both a real winner and the spurious code.

With eight levels the bench can also stage layered nesting. One level is held in service while requests arrive above it, at it, and below it. The same stimulus is then run under both nesting rules, and again under automatic retirement.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
  typedef struct packed {
    logic special;
    logic aeoi;
  } nest_mode_t;
endpackage

// File: rtl/irqn_prio_pick.sv
module irqn_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_scan
    assign onehot_o[i] = vec_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | vec_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  // R3: a single winner at most
  always_comb begin
    a_onehot_r3: assert ($onehot0(onehot_o));
  end
endmodule

// File: rtl/irqn_gate.sv
module irqn_gate #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          pend_any_i,
  input  logic [IW-1:0] pend_idx_i,
  input  logic          svc_any_i,
  input  logic [IW-1:0] svc_idx_i,
  input  logic          special_i,
  output logic          grant_o
);
  logic beats;

  always_comb begin
    if (special_i) beats = (pend_idx_i <= svc_idx_i);
    else           beats = (pend_idx_i <  svc_idx_i);
    grant_o = pend_any_i && (!svc_any_i || beats);
  end
endmodule

// File: rtl/irqn_resolver.sv
module irqn_resolver #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          special_i,
  input  logic          aeoi_i,
  input  logic [N-1:0]  req_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  output logic          int_o,
  output logic [IW-1:0] vec_o,
  output logic [N-1:0]  isr_o
);
  import irqn_pkg::*;

  nest_mode_t mode;
  assign mode = '{special: special_i, aeoi: aeoi_i};

  logic [N-1:0]  irr_q, isr_q, aeoi_mask_q;
  logic          int_q, ack_d, aeoi_pend_q;
  logic [IW-1:0] vec_q;

  logic [N-1:0]  win_oh, svc_oh;
  logic [IW-1:0] win_idx, svc_idx;
  logic          win_any, svc_any, grant;

  irqn_prio_pick #(.N(N), .IW(IW)) u_pend (
    .vec_i(irr_q), .onehot_o(win_oh), .idx_o(win_idx), .any_o(win_any)
  );

  irqn_prio_pick #(.N(N), .IW(IW)) u_svc (
    .vec_i(isr_q), .onehot_o(svc_oh), .idx_o(svc_idx), .any_o(svc_any)
  );

  irqn_gate #(.N(N), .IW(IW)) u_gate (
    .pend_any_i(win_any), .pend_idx_i(win_idx),
    .svc_any_i(svc_any),  .svc_idx_i(svc_idx),
    .special_i(mode.special), .grant_o(grant)
  );

  logic          ack_rise, ack_fall;
  logic [N-1:0]  set_mask, eoi_mask, aeoi_clr;

  always_comb begin
    ack_rise = ack_i & ~ack_d;
    ack_fall = ~ack_i & ack_d;
    set_mask = (ack_rise && grant) ? win_oh : '0;
    eoi_mask = eoi_i ? svc_oh : '0;
    aeoi_clr = (ack_fall && aeoi_pend_q) ? aeoi_mask_q : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q       <= '0;
      isr_q       <= '0;
      int_q       <= 1'b0;
      ack_d       <= 1'b0;
      vec_q       <= '0;
      aeoi_pend_q <= 1'b0;
      aeoi_mask_q <= '0;
    end else begin
      irr_q <= req_i & ~set_mask;
      isr_q <= (isr_q & ~eoi_mask & ~aeoi_clr) | set_mask;
      int_q <= grant;
      ack_d <= ack_i;
      if (ack_rise) begin
        vec_q       <= grant ? win_idx : IW'(N - 1);
        aeoi_pend_q <= mode.aeoi & grant;
        aeoi_mask_q <= win_oh;
      end else if (ack_fall) begin
        aeoi_pend_q <= 1'b0;
      end
    end
  end

  assign int_o = int_q;
  assign vec_o = vec_q;
  assign isr_o = isr_q;

  p_int_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    int_q |-> $past(|irr_q));

  p_ack_sets_isr_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_rise && grant && !eoi_i) |=> ((isr_q & $past(win_oh)) != '0));

  p_normal_blocks_equal_r5: assert property (@(posedge clk) disable iff (rst)
    (!special_i && grant && svc_any) |-> (win_oh < svc_oh));

  p_eoi_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && !ack_rise && !ack_fall && isr_q != '0)
      |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  p_spurious_keeps_isr_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_rise && !grant && !eoi_i) |=> $stable(isr_q));
endmodule

// File: tb/sim_irqn_resolver.sv
module sim_irqn_resolver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       special_i = 1'b0, aeoi_i = 1'b0, ack_i = 1'b0, eoi_i = 1'b0;
  logic [7:0] req_i = '0;
  logic       int_o;
  logic [2:0] vec_o;
  logic [7:0] isr_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irqn_resolver u0 (
    .clk(clk), .rst(rst), .special_i(special_i), .aeoi_i(aeoi_i),
    .req_i(req_i), .ack_i(ack_i), .eoi_i(eoi_i),
    .int_o(int_o), .vec_o(vec_o), .isr_o(isr_o)
  );

  // {special, aeoi, req[8], exp_int, exp_vec[3], exp_isr[8]}
  localparam int NV = 6;
  localparam logic [21:0] TBL [NV] = '{
    {1'b0, 1'b0, 8'h00, 1'b0, 3'd7, 8'h00},
    {1'b0, 1'b0, 8'h90, 1'b1, 3'd4, 8'h10},
    {1'b0, 1'b0, 8'h01, 1'b1, 3'd0, 8'h01},
    {1'b0, 1'b1, 8'h0C, 1'b1, 3'd2, 8'h00},
    {1'b1, 1'b0, 8'h80, 1'b1, 3'd7, 8'h80},
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd0, 8'h01}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_i = '0; ack_i = 0; eoi_i = 0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; tick(1); ack_i = 1'b0; tick(1);
  endtask

  task automatic pulse_eoi();
    eoi_i = 1'b1; tick(1); eoi_i = 1'b0; tick(1);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1 int_o", int_o, 0);
    chk("R1 isr_o", isr_o, 0);
    chk("R1 vec_o", vec_o, 0);

    for (int k = 0; k < NV; k++) begin
      do_reset();
      special_i = TBL[k][21]; aeoi_i = TBL[k][20]; req_i = TBL[k][19:12];
      tick(4);
      chk($sformatf("R2 int vec%0d", k), int_o, TBL[k][11]);
      pulse_ack();
      tick(2);
      chk($sformatf("R3 R9 vec vec%0d", k), vec_o, TBL[k][10:8]);
      chk($sformatf("R4 R8 isr vec%0d", k), isr_o, TBL[k][7:0]);
    end

    // normal nesting
    do_reset();
    special_i = 0; aeoi_i = 0; req_i = 8'h08;
    tick(4); pulse_ack(); tick(3);
    chk("R4 isr level3", isr_o, 8'h08);
    chk("R5 same level blocked", int_o, 0);
    req_i = 8'h28; tick(4);
    chk("R5 lower level blocked", int_o, 0);
    req_i = 8'h2A; tick(4);
    chk("R2 higher level passes", int_o, 1);
    pulse_ack(); tick(3);
    chk("R3 nested vec", vec_o, 3'd1);
    chk("R4 nested isr", isr_o, 8'h0A);
    chk("R5 all blocked", int_o, 0);
    pulse_eoi(); tick(2);
    chk("R7 eoi clears top", isr_o, 8'h08);
    chk("R2 reraise after eoi", int_o, 1);
    req_i = 8'h00; pulse_eoi(); tick(3);
    chk("R7 eoi clears last", isr_o, 8'h00);
    chk("R2 idle low", int_o, 0);

    // special nesting
    do_reset();
    special_i = 1; req_i = 8'h08;
    tick(4); pulse_ack(); tick(3);
    chk("R6 isr level3", isr_o, 8'h08);
    chk("R6 same level recognized", int_o, 1);
    req_i = 8'h20; tick(4);
    chk("R6 lower level blocked", int_o, 0);

    // automatic retirement timing
    do_reset();
    special_i = 0; aeoi_i = 1; req_i = 8'h40;
    tick(4);
    ack_i = 1'b1; tick(1);
    chk("R8 isr during pulse", isr_o, 8'h40);
    tick(1);
    chk("R8 isr held while high", isr_o, 8'h40);
    ack_i = 1'b0; tick(1);
    chk("R8 isr cleared at pulse end", isr_o, 8'h00);
    chk("R3 aeoi vec", vec_o, 3'd6);

    // spurious with a level in service
    do_reset();
    aeoi_i = 0; req_i = 8'h04;
    tick(4); pulse_ack(); req_i = 8'h00; tick(3);
    pulse_ack(); tick(2);
    chk("R9 spurious vec", vec_o, 3'd7);
    chk("R9 spurious isr", isr_o, 8'h04);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule